// File: doc/BRIEF.md
# Four-Mode SPI Master

This block is a single-slave SPI master. Each accepted start request runs one full-duplex word exchange: the transmit word shifts out on MOSI with the most significant bit first, and at the same time a word is gathered from MISO. When the frame ends, the gathered word appears on the received-word output. Two mode inputs give the clock polarity and the clock phase. The block samples them when it accepts a start and holds them until the frame ends, so each transfer can use a different one of the four SPI modes.

SCLK is made from the system clock by a divider. Each half period of SCLK lasts `HALF_DIV` system cycles, so SCLK runs at the system clock divided by twice `HALF_DIV`, and `HALF_DIV` must be 2 or more. One datapath serves all four modes. The current SCLK level is XORed with the latched polarity and phase bits, and the result marks each divider tick as a sample edge or a shift edge. When the phase bit is 1, the first edge of the frame is a shift edge. Chip select frames the whole exchange. The `busy` output is high for the length of the frame, and `done` is a one-cycle pulse.

Top module: `spi_mode_master`

## Requirements
- R1: When no transfer is running and `mode_pol` has been steady for at least one cycle, `sclk` equals `mode_pol` (0 idles low, 1 idles high). This holds after reset and after every transfer.
- R2: `cs_n` goes low and `busy` goes high on the clock edge that accepts `start` while idle. Both return to idle (`cs_n` high, `busy` low) on the edge that raises `done`.
- R3: The mode is the pair {`mode_pol`,`mode_pha`}. MISO is sampled on the rising SCLK edge when the two bits are equal (modes 0 and 3) and on the falling edge when they differ (modes 1 and 2). Sampled bits fill the received word from the most significant bit down.
- R4: MOSI carries the transmit word with the most significant bit first, and it changes only on shift edges, which are the edges opposite to the sample edges. With phase 0 the first bit is on MOSI from the falling edge of chip select, before the first SCLK edge. With phase 1 the first bit is valid by the first edge, and that first shift edge does not advance the register.
- R5: Every frame has exactly 2×W SCLK edges. Edges are `HALF_DIV` system cycles apart, and the first edge comes `HALF_DIV` cycles after chip select falls. `done` rises `HALF_DIV`×(2×W+1) clock edges after the edge that accepted `start`.
- R6: `done` is high for exactly one system cycle per frame.
- R7: `rx_data` changes only in the cycle in which `done` is high.
- R8: With MISO tied to MOSI, `rx_data` equals the transmitted word in all four modes.
- R9: A `start` that arrives while `busy` is high is ignored: it does not start another frame and it does not change the words exchanged. A change of `mode_pol` or `mode_pha` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a frame; accepted only while idle |
| tx_data | input | W | Word to transmit, captured when a start is accepted |
| mode_pol | input | 1 | Clock polarity: the idle level of SCLK |
| mode_pha | input | 1 | Clock phase: 1 means the first edge is a shift edge |
| rx_data | output | W | Received word, updated when `done` pulses |
| busy | output | 1 | High while a frame is running |
| done | output | 1 | One-cycle pulse at the end of a frame |
| sclk | output | 1 | Serial clock to the slave |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench runs every mode against a slave model that moves its own word out on the opposite edges, and then runs every mode again with MISO looped back. This shows where an edge choice is swapped. A design with the phase-1 skip missing would lose the top bit and shift the received word by one place. A design that chose the wrong edge for sampling would read each bit half a period early or late. The bench also counts SCLK edges and measures frame latency, which exposes an off-by-one edge count or a wrong divider. It then raises `start` again during a frame and flips the mode inputs during a frame. A design that accepted either one would send a second frame or clock the current frame in a different mode.

// File: rtl/spi_mode_pkg.sv
package spi_mode_pkg;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  // A divider tick is a sample edge when the level before the toggle,
  // XOR polarity, XOR phase, gives zero.
  function automatic logic is_sample_edge(input logic lvl,
                                          input logic pol,
                                          input logic pha);
    return ~(lvl ^ pol ^ pha);
  endfunction

endpackage

// File: rtl/spi_mode_divider.sv
module spi_mode_divider #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  initial begin
    if (HALF_DIV < 2) $error("HALF_DIV must be 2 or more");
  end

endmodule

// File: rtl/spi_mode_shifter.sv
module spi_mode_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift_en,
  input  logic         sample_en,
  input  logic         publish,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] out_sr;
  logic [W-1:0] in_sr;

  assign mosi = out_sr[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sr <= '0;
    end else if (load) begin
      out_sr <= load_word;
    end else if (shift_en) begin
      out_sr <= {out_sr[W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sr <= '0;
    end else if (load) begin
      in_sr <= '0;
    end else if (sample_en) begin
      in_sr <= {in_sr[W-2:0], miso};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_word <= '0;
    end else if (publish) begin
      rx_word <= in_sr;
    end
  end

  AST_NO_SHIFT_AND_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !(shift_en && sample_en)) else $error("shift and sample in one cycle"); // R4

endmodule

// File: rtl/spi_mode_ctrl.sv
module spi_mode_ctrl
  import spi_mode_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mode_pol,
  input  logic mode_pha,
  input  logic tick,
  output logic run,
  output logic load,
  output logic shift_en,
  output logic sample_en,
  output logic publish,
  output logic sclk,
  output logic cs_n,
  output logic busy,
  output logic done
);
  localparam int EDGES = 2 * W;
  localparam int EC_W  = $clog2(EDGES + 1);
  localparam logic [EC_W-1:0] EDGES_V = EC_W'(EDGES);

  phase_t          ph;
  logic            pol_q;
  logic            pha_q;
  logic [EC_W-1:0] edge_cnt;
  logic            last_tick;
  logic            samp_now;

  assign run       = (ph == PH_RUN);
  assign load      = (ph == PH_IDLE) && start;
  assign last_tick = run && tick && (edge_cnt == EDGES_V);
  assign samp_now  = is_sample_edge(sclk, pol_q, pha_q);
  assign sample_en = run && tick && !last_tick && samp_now;
  assign shift_en  = run && tick && !last_tick && !samp_now
                     && !(pha_q && (edge_cnt == '0));
  assign publish   = last_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      pol_q    <= 1'b0;
      pha_q    <= 1'b0;
      edge_cnt <= '0;
      sclk     <= mode_pol;
      cs_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          sclk <= mode_pol;
          if (start) begin
            pol_q    <= mode_pol;
            pha_q    <= mode_pha;
            edge_cnt <= '0;
            cs_n     <= 1'b0;
            busy     <= 1'b1;
            ph       <= PH_RUN;
          end
        end
        PH_RUN: begin
          if (last_tick) begin
            sclk <= pol_q;
            cs_n <= 1'b1;
            busy <= 1'b0;
            done <= 1'b1;
            ph   <= PH_IDLE;
          end else if (tick) begin
            sclk     <= ~sclk;
            edge_cnt <= edge_cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done wider than one cycle"); // R6

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(pol_q) && $stable(pha_q)))
    else $error("mode changed inside a frame"); // R9

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && !$past(rst) && $stable(mode_pol)) |-> (sclk == mode_pol))
    else $error("idle clock level wrong"); // R1

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> !cs_n || done)
    else $error("start while busy disturbed the frame"); // R9

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master #(
  parameter int W        = 8,
  parameter int HALF_DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_data,
  input  logic         mode_pol,
  input  logic         mode_pha,
  output logic [W-1:0] rx_data,
  output logic         busy,
  output logic         done,
  output logic         sclk,
  output logic         mosi,
  input  logic         miso,
  output logic         cs_n
);
  localparam int EDGES = 2 * W;
  localparam int SEEN_W = $clog2(EDGES + 2);

  logic run, tick, load, shift_en, sample_en, publish;

  spi_mode_divider #(.HALF_DIV(HALF_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  spi_mode_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mode_pol  (mode_pol),
    .mode_pha  (mode_pha),
    .tick      (tick),
    .run       (run),
    .load      (load),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .publish   (publish),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done)
  );

  spi_mode_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_word (tx_data),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .publish   (publish),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data)
  );

  // Edge tally used only by the frame-length check below.
  logic              sclk_d, cs_d;
  logic [SEEN_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      seen   <= '0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (cs_d && !cs_n) begin
        seen <= '0;
      end else if (!cs_n && (sclk != sclk_d) && (seen != '1)) begin
        seen <= seen + 1'b1;
      end
    end
  end

  AST_EDGE_TOTAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (seen == SEEN_W'(EDGES))) else $error("edge count wrong"); // R5

  AST_RX_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_data) |-> done) else $error("rx_data moved outside done"); // R7

  AST_CS_FRAMES_BUSY: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> busy) else $error("chip select low while idle"); // R2

endmodule

// File: tb/test_spi_mode_master.sv
module test_spi_mode_master;
  localparam int W = 8;
  localparam int HALF_DIV = 4;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY = HALF_DIV * (2 * W + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic mode_pol = 1'b1;
  logic mode_pha = 1'b0;
  logic [W-1:0] rx_data;
  logic busy, done, sclk, mosi, miso, cs_n;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // slave model state
  logic [W-1:0] s_word = '0;
  logic [W-1:0] s_cap = '0;
  logic s_miso = 1'b0;
  logic s_pol = 1'b0;
  logic s_pha = 1'b0;
  logic loopback = 1'b0;
  int   s_idx = 0;

  assign miso = loopback ? mosi : s_miso;

  typedef struct {
    logic [W-1:0] rx_exp;
    logic [W-1:0] cap_exp;
    logic         pol;
    int           t0;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_mode_master #(.W(W), .HALF_DIV(HALF_DIV)) i_spi_mode_master (
    .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
    .mode_pol(mode_pol), .mode_pha(mode_pha), .rx_data(rx_data),
    .busy(busy), .done(done), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Slave: presents its word on shift edges, captures MOSI on sample edges.
  always @(negedge cs_n) begin
    s_cap = '0;
    if (!s_pha) begin
      s_idx  = W - 1;
      s_miso = s_word[W-1];
    end else begin
      s_idx = W;
    end
  end

  always @(sclk) begin
    if (!cs_n) begin
      if ((sclk == 1'b1) == (s_pol == s_pha)) begin
        s_cap = {s_cap[W-2:0], mosi};
      end else begin
        s_idx = s_idx - 1;
        if (s_idx >= 0) s_miso = s_word[s_idx];
      end
    end
  end

  // Monitor: edge tally, rx stability, scoreboard compare on done.
  logic sclk_prev = 1'b0, cs_prev = 1'b1, done_prev = 1'b0;
  logic [W-1:0] last_rx = '0;
  int edges = 0;
  int r7_bad = 0;
  int r6_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cs_prev && !cs_n) edges = 0;
      else if (!cs_n && sclk != sclk_prev) edges++;
      if (!done && rx_data !== last_rx) r7_bad++;
      if (done && done_prev) r6_bad++;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(rx_data === e.rx_exp, "R3/R8 received word", 32'(rx_data), 32'(e.rx_exp));
          chk(s_cap === e.cap_exp, "R4 slave captured word", 32'(s_cap), 32'(e.cap_exp));
          chk(edges == 2 * W, "R5 edge count", 32'(edges), 32'(2 * W));
          chk(cyc - e.t0 == LATENCY, "R5 frame latency", 32'(cyc - e.t0), 32'(LATENCY));
          chk(sclk === e.pol, "R1 idle level at end", 32'(sclk), 32'(e.pol));
          chk(cs_n === 1'b1 && busy === 1'b0, "R2 frame release",
              32'({cs_n, busy}), 32'b10);
        end
        last_rx = rx_data;
      end
      sclk_prev = sclk;
      cs_prev   = cs_n;
      done_prev = done;
    end
  end

  task automatic xfer(input logic [W-1:0] tx, input logic [W-1:0] sw,
                      input logic pol, input logic pha, input logic lb,
                      input bit late_start, input bit flip_mode);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    s_word = sw; s_pol = pol; s_pha = pha; loopback = lb;
    mode_pol = pol; mode_pha = pha;
    @(negedge clk);
    tx_data = tx; start = 1'b1;
    e.rx_exp = lb ? tx : sw;
    e.cap_exp = tx;
    e.pol = pol;
    e.t0 = cyc + 1;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    chk(cs_n === 1'b0 && busy === 1'b1, "R2 frame open", 32'({cs_n, busy}), 32'b01);
    chk(mosi === tx[W-1], "R4 first bit before first edge", 32'(mosi), 32'(tx[W-1]));
    if (late_start) begin
      repeat (10) @(negedge clk);
      tx_data = ~tx; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (flip_mode) begin
      mode_pol = ~pol; mode_pha = ~pha;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sclk === mode_pol && cs_n === 1'b1, "R1 idle level after frame",
        32'(sclk), 32'(mode_pol));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cyc), 32'd0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk === 1'b1, "R1 idle high after reset", 32'(sclk), 32'd1);
    chk(cs_n === 1'b1 && busy === 1'b0 && done === 1'b0, "R2 reset state",
        32'({cs_n, busy, done}), 32'b100);
    chk(rx_data === '0, "R7 reset rx", 32'(rx_data), 32'd0);
    mode_pol = 1'b0;
    repeat (2) @(negedge clk);
    chk(sclk === 1'b0, "R1 idle low", 32'(sclk), 32'd0);

    for (int m = 0; m < 4; m++) begin
      xfer(8'hA5 ^ 8'(m * 17), 8'h3C + 8'(m * 29), m[1], m[0], 1'b0, 0, 0); // R3 R4
    end
    for (int m = 0; m < 4; m++) begin
      xfer(8'h69 + 8'(m * 53), 8'h00, m[1], m[0], 1'b1, 0, 0); // R8 loopback
    end
    xfer(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 0, 0);
    xfer(8'h00, 8'hFF, 1'b1, 1'b0, 1'b0, 0, 0);
    xfer(8'h81, 8'h7E, 1'b1, 1'b1, 1'b0, 1, 0); // R9 start while busy
    xfer(8'h5A, 8'hC3, 1'b0, 1'b1, 1'b0, 0, 1); // R9 mode change mid-frame

    repeat (HALF_DIV * 4) @(negedge clk);
    chk(sb.size() == 0, "R9 frames completed", 32'(sb.size()), 32'd0);
    chk(r7_bad == 0, "R7 rx stable outside done", 32'(r7_bad), 32'd0);
    chk(r6_bad == 0, "R6 done single cycle", 32'(r6_bad), 32'd0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule